// File: doc/BRIEF.md
# Display Link Training Sequencer

This block runs the two-phase bring-up of a multi-lane serial display link. It talks to the sink only through an abstract register request port. Each request is a single read or write of one to four consecutive bytes at a sink address. The block first programs the link rate and the lane count. It then runs clock recovery under training pattern 1 and channel equalisation under pattern 2. Between status polls it merges the sink's per-lane drive-adjust requests into one common drive byte, which it applies to every active lane.

A pass that fails at any rate other than the lowest (code 0x06) is repeated once at the lowest rate. Every pass ends by writing pattern 0. When the sequence finishes, the block gives a one-cycle `done`, a pass/fail flag and the rate code that was used. Wait times between a drive commit and a status read are counted in clock cycles. The defaults are 100 us and 400 us at 50 MHz.

Top module: `link_train_seq`

## Requirements
- R1: A pass writes the rate code to address 0x100 and then the lane count to 0x101. The lane-count byte carries bit 7 set only when `sink_rev` >= 0x11 and `sink_enh` is 1.
- R2: Clock recovery writes pattern 1 to address 0x102. Its first drive commit to 0x103 (four bytes, lane i in byte i) is all zeros.
- R3: Each lane's status is the nibble in byte i>>1 at bit (i&1)*4, with bit 0 meaning clock-recovery done. When every active lane shows bit 0 after a two-byte read of 0x202, pattern 2 is written next.
- R4: The adjust request is two bytes read from 0x206, using the same nibble layout, with swing in bits 1:0 and pre-emphasis in bits 3:2. The block takes the maximum swing and the maximum pre-emphasis over the active lanes only. It writes drive byte (pre<<3)|swing to the active lanes and zero to the others.
- R5: A merged swing that is >= `swing_max` becomes `swing_max` with bit 2 set. A merged pre-emphasis that is >= `pre_max` becomes `pre_max` with bit 2 of its field set, which is bit 5 of the drive byte.
- R6: Clock recovery ends without success as soon as a failing status is seen while bit 5 of the committed drive byte is set.
- R7: The try count restarts whenever the committed swing differs from the one seen at the previous status read. Clock recovery fails after 5 status reads at the same swing.
- R8: Equalisation reads three bytes from 0x202, at most 6 times. It succeeds when bit 0 of the third byte is set and every active lane's nibble has bits 0, 1 and 2 set. Otherwise it adjusts and re-commits the drive between reads.
- R9: A missing clock-recovery bit on any active lane during equalisation ends the phase without success.
- R10: Every pass ends with a write of pattern 0 to 0x102 before the next pass or before `done`.
- R11: After a failed pass at a rate other than 0x06, the whole sequence repeats once at rate 0x06.
- R12: `done` is a one-cycle pulse, and `pass` and `rate_used` are valid while it is high. A request holds its address, direction and data until `rq_done`. No request is made while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a training sequence when idle |
| rate_code | input | 8 | Initial link-rate code |
| lane_nr | input | 3 | Number of active lanes (1, 2 or 4) |
| sink_rev | input | 8 | Sink capability revision |
| sink_enh | input | 1 | Sink supports enhanced framing |
| swing_max | input | 2 | Highest allowed swing level |
| pre_max | input | 2 | Highest allowed pre-emphasis level |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pass | output | 1 | Last sequence succeeded |
| rate_used | output | 8 | Rate code of the final pass |
| rq_valid | output | 1 | Register request pending |
| rq_write | output | 1 | 1 = write, 0 = read |
| rq_addr | output | 20 | Sink register address |
| rq_len | output | 3 | Byte count |
| rq_wdata | output | 32 | Write bytes, first byte in bits 7:0 |
| rq_done | input | 1 | Request completed this cycle |
| rq_rdata | input | 24 | Read bytes, first byte in bits 7:0 |

## Verification
The bound checker watches every cycle for several things. It checks that a pending request holds steady until accepted and that nothing is requested while idle. It checks that `done` is a single pulse that follows an accepted pattern-0 write. On every drive write it checks that the lane bytes agree, and that a set limit flag comes with a level equal to the matching maximum input. Some behaviour depends on a sink's answers over many polls, so only the bench scenarios can show it. This covers the try counting and its restart on a swing change, the early stop on the pre-emphasis flag, the loss of clock recovery during equalisation, and the single fallback to the low rate. It also covers merging over active lanes only and the enhanced-framing bit.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam logic [19:0] ADR_RATE  = 20'h00100;
  localparam logic [19:0] ADR_LANES = 20'h00101;
  localparam logic [19:0] ADR_PAT   = 20'h00102;
  localparam logic [19:0] ADR_DRIVE = 20'h00103;
  localparam logic [19:0] ADR_STAT  = 20'h00202;
  localparam logic [19:0] ADR_ADJ   = 20'h00206;
  localparam logic [7:0]  RATE_LOW  = 8'h06;
  localparam logic [7:0]  REV_ENH   = 8'h11;

  typedef enum logic [3:0] {
    S_IDLE, S_RATE, S_LANES, S_PAT1, S_CR_COMMIT, S_CR_WAIT, S_CR_READ,
    S_CR_ADJ, S_PAT2, S_EQ_WAIT, S_EQ_READ, S_EQ_ADJ, S_EQ_COMMIT,
    S_PAT0, S_FIN
  } lts_state_e;
endpackage

// File: rtl/lts_wait_timer.sv
module lts_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = len - W'(1);
    else if (cnt_q != '0)  cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/lts_lane_status.sv
module lts_lane_status #(
  parameter int MAX_LANES = 4,
  localparam int LN_W = $clog2(MAX_LANES + 1),
  localparam int NB   = (MAX_LANES + 1) / 2,
  localparam int ST_W = 8 * (NB + 1)
) (
  input  logic [ST_W-1:0] stat,
  input  logic [LN_W-1:0] lane_nr,
  output logic            cr_all,
  output logic            cr_lost,
  output logic            eq_all
);
  logic [MAX_LANES-1:0] act, cr_v, ok_v;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    logic [3:0] nib;
    assign nib     = stat[(i / 2) * 8 + (i % 2) * 4 +: 4];
    assign act[i]  = (LN_W'(i) < lane_nr);
    assign cr_v[i] = nib[0];
    assign ok_v[i] = &nib[2:0];
  end

  assign cr_all  = &(cr_v | ~act);
  assign cr_lost = |(~cr_v & act);
  assign eq_all  = stat[8 * NB] && (&(ok_v | ~act));
endmodule

// File: rtl/lts_adjust_merge.sv
module lts_adjust_merge #(
  parameter int MAX_LANES = 4,
  localparam int LN_W  = $clog2(MAX_LANES + 1),
  localparam int ADJ_W = 8 * ((MAX_LANES + 1) / 2)
) (
  input  logic [ADJ_W-1:0] adj,
  input  logic [LN_W-1:0]  lane_nr,
  input  logic [1:0]       swing_max,
  input  logic [1:0]       pre_max,
  output logic [5:0]       drive
);
  logic [1:0] sw_l [MAX_LANES];
  logic [1:0] pr_l [MAX_LANES];
  logic [1:0] sw_m, pr_m;
  logic       sw_hit, pr_hit;

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_req
    assign sw_l[i] = adj[(i / 2) * 8 + (i % 2) * 4 +: 2];
    assign pr_l[i] = adj[(i / 2) * 8 + (i % 2) * 4 + 2 +: 2];
  end

  always_comb begin
    sw_m = '0;
    pr_m = '0;
    for (int i = 0; i < MAX_LANES; i++) begin
      if (LN_W'(i) < lane_nr) begin
        if (sw_l[i] > sw_m) sw_m = sw_l[i];
        if (pr_l[i] > pr_m) pr_m = pr_l[i];
      end
    end
  end

  assign sw_hit = (sw_m >= swing_max);
  assign pr_hit = (pr_m >= pre_max);
  assign drive  = {pr_hit, (pr_hit ? pre_max : pr_m),
                   sw_hit, (sw_hit ? swing_max : sw_m)};
endmodule

// File: rtl/link_train_seq.sv
module link_train_seq
  import lts_pkg::*;
#(
  parameter int MAX_LANES   = 4,
  parameter int CR_WAIT_CYC = 5000,
  parameter int EQ_WAIT_CYC = 20000,
  parameter int CR_TRIES    = 5,
  parameter int EQ_TRIES    = 6,
  localparam int LN_W  = $clog2(MAX_LANES + 1),
  localparam int NB    = (MAX_LANES + 1) / 2,
  localparam int ST_W  = 8 * (NB + 1),
  localparam int ADJ_W = 8 * NB,
  localparam int WD_W  = 8 * MAX_LANES,
  localparam int TMR_W = $clog2((CR_WAIT_CYC > EQ_WAIT_CYC ? CR_WAIT_CYC : EQ_WAIT_CYC) + 1),
  localparam int TRY_W = $clog2((CR_TRIES > EQ_TRIES ? CR_TRIES : EQ_TRIES) + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       rate_code,
  input  logic [LN_W-1:0]  lane_nr,
  input  logic [7:0]       sink_rev,
  input  logic             sink_enh,
  input  logic [1:0]       swing_max,
  input  logic [1:0]       pre_max,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [7:0]       rate_used,
  output logic             rq_valid,
  output logic             rq_write,
  output logic [19:0]      rq_addr,
  output logic [2:0]       rq_len,
  output logic [WD_W-1:0]  rq_wdata,
  input  logic             rq_done,
  input  logic [ST_W-1:0]  rq_rdata
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  lts_state_e       state_q, state_d;
  logic [7:0]       rate_q, rate_d;
  logic [5:0]       drive_q, drive_d;
  logic [TRY_W-1:0] tries_q, tries_d, tries_inc;
  logic [1:0]       swing_q, swing_d;
  logic             swv_q, swv_d;
  logic             succ_q, succ_d;
  logic             pass_q, pass_d;
  logic [7:0]       used_q, used_d;

  logic             cr_all, cr_lost, eq_all;
  logic [5:0]       drive_adj;
  logic             wt_load, wt_exp;
  logic [TMR_W-1:0] wt_len;
  logic [WD_W-1:0]  drive_word;
  logic [7:0]       lane_byte;

  lts_lane_status #(.MAX_LANES(MAX_LANES)) u_stat (
    .stat(rq_rdata), .lane_nr(lane_nr),
    .cr_all(cr_all), .cr_lost(cr_lost), .eq_all(eq_all)
  );

  lts_adjust_merge #(.MAX_LANES(MAX_LANES)) u_merge (
    .adj(rq_rdata[ADJ_W-1:0]), .lane_nr(lane_nr),
    .swing_max(swing_max), .pre_max(pre_max), .drive(drive_adj)
  );

  lts_wait_timer #(.W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_ni), .load(wt_load), .len(wt_len), .expired(wt_exp)
  );

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_drv
    assign drive_word[i*8 +: 8] = (LN_W'(i) < lane_nr) ? {2'b00, drive_q} : 8'h00;
  end

  assign lane_byte = {((sink_rev >= REV_ENH) && sink_enh), {(7 - LN_W){1'b0}}, lane_nr};
  assign tries_inc = tries_q + TRY_W'(1);

  // timer loads on entry to either wait state
  assign wt_load = rq_done && ((state_q == S_CR_COMMIT) || (state_q == S_PAT2) ||
                               (state_q == S_EQ_COMMIT));
  assign wt_len  = (state_q == S_CR_COMMIT) ? TMR_W'(CR_WAIT_CYC) : TMR_W'(EQ_WAIT_CYC);

  // request decode
  always_comb begin
    rq_valid = 1'b1;
    rq_write = 1'b1;
    rq_addr  = ADR_PAT;
    rq_len   = 3'd1;
    rq_wdata = '0;
    unique case (state_q)
      S_RATE:  begin rq_addr = ADR_RATE;  rq_wdata[7:0] = rate_q; end
      S_LANES: begin rq_addr = ADR_LANES; rq_wdata[7:0] = lane_byte; end
      S_PAT1:  rq_wdata[7:0] = 8'h01;
      S_PAT2:  rq_wdata[7:0] = 8'h02;
      S_PAT0:  rq_wdata[7:0] = 8'h00;
      S_CR_COMMIT, S_EQ_COMMIT: begin
        rq_addr = ADR_DRIVE; rq_len = 3'(MAX_LANES); rq_wdata = drive_word;
      end
      S_CR_READ: begin rq_write = 1'b0; rq_addr = ADR_STAT; rq_len = 3'(NB); end
      S_EQ_READ: begin rq_write = 1'b0; rq_addr = ADR_STAT; rq_len = 3'(NB + 1); end
      S_CR_ADJ, S_EQ_ADJ: begin rq_write = 1'b0; rq_addr = ADR_ADJ; rq_len = 3'(NB); end
      default: rq_valid = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    state_d = state_q;
    rate_d  = rate_q;
    drive_d = drive_q;
    tries_d = tries_q;
    swing_d = swing_q;
    swv_d   = swv_q;
    succ_d  = succ_q;
    pass_d  = pass_q;
    used_d  = used_q;
    unique case (state_q)
      S_IDLE: if (start) begin
        rate_d  = rate_code;
        succ_d  = 1'b0;
        state_d = S_RATE;
      end
      S_RATE:  if (rq_done) state_d = S_LANES;
      S_LANES: if (rq_done) begin
        drive_d = '0; tries_d = '0; swv_d = 1'b0;
        state_d = S_PAT1;
      end
      S_PAT1:      if (rq_done) state_d = S_CR_COMMIT;
      S_CR_COMMIT: if (rq_done) state_d = S_CR_WAIT;
      S_CR_WAIT:   if (wt_exp)  state_d = S_CR_READ;
      S_CR_READ: if (rq_done) begin
        swing_d = drive_q[1:0];
        swv_d   = 1'b1;
        tries_d = (!swv_q || (drive_q[1:0] != swing_q)) ? TRY_W'(1) : tries_inc;
        if (cr_all)                                    state_d = S_PAT2;
        else if (drive_q[5] || tries_d == TRY_W'(CR_TRIES)) state_d = S_PAT0;
        else                                           state_d = S_CR_ADJ;
      end
      S_CR_ADJ: if (rq_done) begin
        drive_d = drive_adj;
        state_d = S_CR_COMMIT;
      end
      S_PAT2: if (rq_done) begin
        tries_d = '0;
        state_d = S_EQ_WAIT;
      end
      S_EQ_WAIT: if (wt_exp) state_d = S_EQ_READ;
      S_EQ_READ: if (rq_done) begin
        if (eq_all) begin
          succ_d  = 1'b1;
          state_d = S_PAT0;
        end else if (cr_lost || tries_q == TRY_W'(EQ_TRIES - 1)) begin
          state_d = S_PAT0;
        end else begin
          tries_d = tries_inc;
          state_d = S_EQ_ADJ;
        end
      end
      S_EQ_ADJ: if (rq_done) begin
        drive_d = drive_adj;
        state_d = S_EQ_COMMIT;
      end
      S_EQ_COMMIT: if (rq_done) state_d = S_EQ_WAIT;
      S_PAT0: if (rq_done) begin
        if (!succ_q && rate_q != RATE_LOW) begin
          rate_d  = RATE_LOW;
          state_d = S_RATE;
        end else begin
          pass_d  = succ_q;
          used_d  = rate_q;
          state_d = S_FIN;
        end
      end
      S_FIN:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      rate_q  <= '0;
      drive_q <= '0;
      tries_q <= '0;
      swing_q <= '0;
      swv_q   <= 1'b0;
      succ_q  <= 1'b0;
      pass_q  <= 1'b0;
      used_q  <= '0;
    end else begin
      state_q <= state_d;
      rate_q  <= rate_d;
      drive_q <= drive_d;
      tries_q <= tries_d;
      swing_q <= swing_d;
      swv_q   <= swv_d;
      succ_q  <= succ_d;
      pass_q  <= pass_d;
      used_q  <= used_d;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_FIN);
  assign pass      = pass_q;
  assign rate_used = used_q;
endmodule

// File: rtl/lts_chk.sv
module lts_chk
  import lts_pkg::*;
#(
  parameter int MAX_LANES = 4,
  localparam int WD_W = 8 * MAX_LANES
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic [1:0]      swing_max,
  input logic [1:0]      pre_max,
  input logic            rq_valid,
  input logic            rq_write,
  input logic [19:0]     rq_addr,
  input logic [WD_W-1:0] rq_wdata,
  input logic            rq_done
);
  logic drv_wr, pat_wr;
  assign drv_wr = rq_valid && rq_write && (rq_addr == ADR_DRIVE);
  assign pat_wr = rq_valid && rq_write && (rq_addr == ADR_PAT);

  p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_done |=> rq_valid && $stable(rq_addr) && $stable(rq_write) && $stable(rq_wdata));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rq_valid);

  p_end_pat0_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rq_done && pat_wr && rq_wdata[7:0] == 8'h00));

  p_pat_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pat_wr |-> rq_wdata[7:0] <= 8'h02);

  p_clamp_sw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_wr && rq_wdata[2] |-> rq_wdata[1:0] == swing_max);

  p_clamp_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drv_wr && rq_wdata[5] |-> rq_wdata[4:3] == pre_max);

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    p_lane_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
      drv_wr |-> rq_wdata[i*8+6 +: 2] == 2'b00 &&
                 (rq_wdata[i*8 +: 8] == 8'h00 || rq_wdata[i*8 +: 8] == rq_wdata[7:0]));
  end
endmodule

bind link_train_seq lts_chk #(.MAX_LANES(MAX_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .swing_max(swing_max), .pre_max(pre_max), .rq_valid(rq_valid),
  .rq_write(rq_write), .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rq_done(rq_done)
);

// File: tb/sim_link_train_seq.sv
`timescale 1ns/1ps
module sim_link_train_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  rate_code = 8'h0A;
  logic [2:0]  lane_nr = 3'd4;
  logic [7:0]  sink_rev = 8'h12;
  logic        sink_enh = 1'b1;
  logic [1:0]  swing_max = 2'd3;
  logic [1:0]  pre_max = 2'd3;
  logic        busy, done, pass;
  logic [7:0]  rate_used;
  logic        rq_valid, rq_write;
  logic [19:0] rq_addr;
  logic [2:0]  rq_len;
  logic [31:0] rq_wdata;
  logic        rq_done = 1'b0;
  logic [23:0] rq_rdata = '0;

  always #10 clk = ~clk;

  link_train_seq #(.CR_WAIT_CYC(4), .EQ_WAIT_CYC(8)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .rate_code(rate_code), .lane_nr(lane_nr),
    .sink_rev(sink_rev), .sink_enh(sink_enh), .swing_max(swing_max), .pre_max(pre_max),
    .busy(busy), .done(done), .pass(pass), .rate_used(rate_used),
    .rq_valid(rq_valid), .rq_write(rq_write), .rq_addr(rq_addr), .rq_len(rq_len),
    .rq_wdata(rq_wdata), .rq_done(rq_done), .rq_rdata(rq_rdata)
  );

  int checks = 0, errors = 0;

  // sink model settings
  int  need_sw, need_pr;
  bit  bad_high_cr, bad_high_eq, drop_cr, one_lane, inc_req;
  int  req_sw, req_pr;
  logic [3:0] lane1_nib;
  // sink model state and log
  logic [7:0]  cur_rate, cur_pat, lane_byte, first_rate;
  logic [31:0] drive_word, first_drive;
  logic [19:0] last_wr;
  int n_rate, n_commit, n_eq, n_adj, order_bad, rsp_cnt;
  bit fresh;
  logic [3:0] pat_seen;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] sink_status();
    logic [3:0] nib;
    bit crb, eqb;
    crb = (int'(drive_word[1:0]) >= need_sw) && !(bad_high_cr && cur_rate == 8'h0A)
          && !(drop_cr && cur_pat == 8'h02);
    eqb = (cur_pat == 8'h02) && (int'(drive_word[4:3]) >= need_pr)
          && !(bad_high_eq && cur_rate == 8'h0A);
    nib = {1'b0, eqb, eqb, crb};
    if (one_lane) return {7'b0, eqb, 8'h00, 4'h0, nib};
    return {7'b0, eqb, nib, nib, nib, nib};
  endfunction

  function automatic logic [23:0] sink_adjust();
    int s;
    logic [3:0] a;
    s = inc_req ? ((n_adj + 1 > 3) ? 3 : n_adj + 1) : req_sw;
    a = {2'(req_pr), 2'(s)};
    return {8'h00, a, a, (one_lane ? lane1_nib : a), a};
  endfunction

  // responder: accepts each request two cycles after it appears
  always @(negedge clk) begin
    if (rq_done) begin
      rq_done = 1'b0;
      rsp_cnt = 0;
    end else if (rq_valid) begin
      rsp_cnt++;
      if (rsp_cnt == 2) begin
        if (rq_write) begin
          case (rq_addr)
            20'h00100: begin n_rate++; cur_rate = rq_wdata[7:0]; if (n_rate == 1) first_rate = cur_rate; end
            20'h00101: begin lane_byte = rq_wdata[7:0]; if (last_wr != 20'h00100) order_bad++; end
            20'h00102: begin cur_pat = rq_wdata[7:0]; pat_seen[cur_pat[1:0]] = 1'b1; if (cur_pat == 8'h01) fresh = 1; end
            20'h00103: begin n_commit++; drive_word = rq_wdata; if (fresh) begin first_drive = rq_wdata; fresh = 0; end end
            default: ;
          endcase
          last_wr = rq_addr;
        end else if (rq_addr == 20'h00202) begin
          rq_rdata = sink_status();
          if (rq_len == 3'd3) n_eq++;
        end else begin
          rq_rdata = sink_adjust();
          n_adj++;
        end
        rq_done = 1'b1;
      end
    end else rsp_cnt = 0;
  end

  task automatic setup_sink(input int nsw, input int npr, input int rsw, input int rpr);
    need_sw = nsw; need_pr = npr; req_sw = rsw; req_pr = rpr;
    bad_high_cr = 0; bad_high_eq = 0; drop_cr = 0; one_lane = 0; inc_req = 0;
    lane1_nib = 4'h0;
    cur_rate = 0; cur_pat = 0; lane_byte = 0; first_rate = 0; drive_word = 0; first_drive = 32'hFFFF_FFFF;
    last_wr = 0; n_rate = 0; n_commit = 0; n_eq = 0; n_adj = 0; order_bad = 0; fresh = 0; pat_seen = 0;
  endtask

  task automatic run(input logic [7:0] rate, input logic [2:0] ln, input logic [7:0] rev,
                     input logic enh, input logic [1:0] smax, input logic [1:0] pmax);
    int w;
    @(negedge clk);
    rate_code = rate; lane_nr = ln; sink_rev = rev; sink_enh = enh; swing_max = smax; pre_max = pmax;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(done == 1'b1, "R12 done seen", done, 1);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && rq_valid == 0 && pass == 0, "R12 reset state",
        {busy, done, rq_valid, pass}, 0);
  endtask

  task automatic t_happy();
    setup_sink(2, 1, 2, 1);
    run(8'h0A, 3'd4, 8'h12, 1'b1, 2'd3, 2'd3);
    chk(pass == 1, "R8 pass", pass, 1);
    chk(rate_used == 8'h0A, "R12 rate_used", rate_used, 8'h0A);
    chk(first_rate == 8'h0A && order_bad == 0, "R1 rate then lanes", order_bad, 0);
    chk(lane_byte == 8'h84, "R1 enhanced lane byte", lane_byte, 8'h84);
    chk(first_drive == 32'h0, "R2 first drive zero", first_drive, 0);
    chk(pat_seen == 4'b0111, "R3 patterns 0,1,2 written", pat_seen, 4'b0111);
    chk(drive_word == 32'h0A0A_0A0A, "R4 merged drive", drive_word, 32'h0A0A0A0A);
    chk(n_commit == 2 && n_eq == 1, "R3 one adjust then eq", n_commit, 2);
    @(negedge clk);
    chk(done == 0, "R12 done pulse", done, 0);
  endtask

  task automatic t_clamp();
    setup_sink(9, 0, 3, 0);
    run(8'h0A, 3'd2, 8'h10, 1'b1, 2'd1, 2'd0);
    chk(lane_byte == 8'h02, "R1 no enhanced below rev", lane_byte, 8'h02);
    chk(drive_word == 32'h0000_2525, "R5 clamped drive", drive_word, 32'h2525);
    chk(n_commit == 4, "R6 early stop on flag", n_commit, 4);
    chk(n_rate == 2 && pass == 0 && rate_used == 8'h06, "R11 fallback once", n_rate, 2);
    chk(cur_pat == 8'h00, "R10 ends with pattern 0", cur_pat, 0);
  endtask

  task automatic t_tries_fixed();
    setup_sink(9, 0, 0, 0);
    run(8'h06, 3'd4, 8'h12, 1'b0, 2'd3, 2'd3);
    chk(n_commit == 5, "R7 five tries same swing", n_commit, 5);
    chk(n_rate == 1 && pass == 0, "R11 no fallback at low rate", n_rate, 1);
    chk(lane_byte == 8'h04, "R1 no enhanced without cap", lane_byte, 8'h04);
  endtask

  task automatic t_tries_restart();
    setup_sink(9, 0, 0, 0);
    inc_req = 1;
    run(8'h06, 3'd4, 8'h12, 1'b1, 2'd3, 2'd3);
    chk(n_commit == 8, "R7 count restarts on swing change", n_commit, 8);
    chk(drive_word[7:0] == 8'h07, "R5 swing flag", drive_word[7:0], 8'h07);
  endtask

  task automatic t_eq_fallback();
    setup_sink(0, 0, 0, 0);
    bad_high_eq = 1;
    run(8'h0A, 3'd4, 8'h12, 1'b1, 2'd3, 2'd3);
    chk(n_eq == 7, "R8 six eq reads then one", n_eq, 7);
    chk(n_commit == 7, "R8 commits between eq reads", n_commit, 7);
    chk(pass == 1 && rate_used == 8'h06, "R11 pass at low rate", rate_used, 8'h06);
  endtask

  task automatic t_cr_drop();
    setup_sink(0, 0, 0, 0);
    drop_cr = 1;
    run(8'h06, 3'd4, 8'h12, 1'b1, 2'd3, 2'd3);
    chk(n_eq == 1 && pass == 0, "R9 cr loss ends eq", n_eq, 1);
    chk(cur_pat == 8'h00, "R10 pattern 0 after failure", cur_pat, 0);
  endtask

  task automatic t_one_lane();
    setup_sink(1, 0, 1, 0);
    one_lane = 1;
    lane1_nib = 4'h3;
    run(8'h0A, 3'd1, 8'h12, 1'b1, 2'd3, 2'd3);
    chk(drive_word == 32'h0000_0001, "R4 active lanes only", drive_word, 1);
    chk(pass == 1 && rate_used == 8'h0A, "R3 single lane pass", pass, 1);
    chk(lane_byte == 8'h81, "R1 one lane enhanced", lane_byte, 8'h81);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rsp_cnt = 0;
    setup_sink(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_happy();
    t_clamp();
    t_tries_fixed();
    t_tries_restart();
    t_eq_fallback();
    t_cr_drop();
    t_one_lane();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule